// File: doc/BRIEF.md
# Byte-Serial Column Mixing Unit

This unit performs the AES column-mixing step on one four-byte state column. All arithmetic runs on an 8-bit datapath. Bytes arrive one per clock over a byte-wide valid/ready input and are kept in a four-entry operand buffer. A small sequencer then drives a shift/XOR ALU that has two accumulators. It builds each result byte from all four buffered bytes and emits the four results in row order, each with a one-cycle valid strobe.

Every field product in GF(2^8) is built from doubling steps. A doubling is a one-bit left shift, followed by an XOR with 0x1B when the top bit of the operand was set. Tripling is a doubling XORed with the operand itself. No general multiplier exists anywhere in the unit. While a column is being processed the input stays closed. It reopens only after the last result byte has left.

Top module: `colmix_serial`

## Requirements
- R1: After a synchronous active-high reset, `inReady` is 1, `outValid` is 0 and the operand buffer holds no bytes. The next four accepted bytes form a fresh column.
- R2: A byte is accepted on a rising edge where both `inValid` and `inReady` are 1. The first accepted byte is row 0, and the following ones are rows 1, 2 and 3.
- R3: From the edge that accepts the fourth byte until the cycle after the row-3 result, `inReady` is 0. Any `inByte`/`inValid` activity in that time has no effect on the results.
- R4: Result row i equals 2·s[i] ^ 3·s[(i+1) mod 4] ^ s[(i+2) mod 4] ^ s[(i+3) mod 4] in GF(2^8) with reduction polynomial x^8+x^4+x^3+x+1. For example, {0xDB,0x13,0x53,0x45} gives {0x8E,0x4D,0xA1,0xBC}.
- R5: Doubling a byte whose top bit is set folds in 0x1B, so the column {0x80,0x00,0x00,0x00} gives {0x1B,0x80,0x80,0x9B}.
- R6: Results come out in row order 0,1,2,3, with `outRow` carrying the row index. `outValid` is a one-cycle pulse. The first result is valid 7 cycles after the edge that accepted the fourth byte, and each later result follows 7 cycles after the one before it.
- R7: In the cycle after the row-3 result, `inReady` is 1 again.
- R8: A reset during loading or during computation discards the partial column. No result is emitted until a new column of four bytes has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inByte | input | 8 | Column byte offered |
| inValid | input | 1 | `inByte` is valid |
| inReady | output | 1 | Unit accepts a byte this cycle |
| outByte | output | 8 | Result byte |
| outRow | output | 2 | Row index of `outByte` |
| outValid | output | 1 | `outByte`/`outRow` valid this cycle |

## Verification
Two things can meet in one cycle: a result leaving on the output and a new byte being offered on the input. The row-3 result is the sharpest case, because the input reopens right after it. The bench keeps `inValid` high with a junk byte during the whole computation and emission. It then checks that `inReady` stayed low up to and including the row-3 pulse, rose in the next cycle, and that the next column is computed correctly with none of the junk bytes taken in. Reset arriving in the middle of loading or computation is the second case, and it is judged by the results of the column that follows.

// File: rtl/colmix_pkg.sv
package colmix_pkg;
  localparam int BYTE_W = 8;
  localparam int ROWS   = 4;
  localparam int ROW_W  = $clog2(ROWS);
  localparam logic [BYTE_W-1:0] REDUCE_TERM = 8'h1B;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_DBL_LEAD,   // acc0 <= dbl(s[i])
    OP_DBL_NEXT,   // acc1 <= dbl(s[i+1])
    OP_FOLD_NEXT,  // acc1 <= acc1 ^ s[i+1]   (completes 3*s[i+1])
    OP_JOIN,       // acc0 <= acc0 ^ acc1
    OP_ADD_THIRD,  // acc0 <= acc0 ^ s[i+2]
    OP_ADD_FOURTH  // acc0 <= acc0 ^ s[i+3]
  } aluOp_e;

  typedef struct packed {
    aluOp_e           op;
    logic [ROW_W-1:0] rowSel;
    logic             push;
    logic [ROW_W-1:0] wrSel;
    logic             emit;
  } ctrlStrobes_t;

  function automatic logic [BYTE_W-1:0] reduceFor(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1] ? REDUCE_TERM : '0;
  endfunction

  function automatic logic [BYTE_W-1:0] dbl(input logic [BYTE_W-1:0] b);
    return {b[BYTE_W-2:0], 1'b0} ^ reduceFor(b);
  endfunction
endpackage

// File: rtl/colmix_datapath.sv
module colmix_datapath
  import colmix_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [BYTE_W-1:0]  inByte,
  output logic [BYTE_W-1:0]  resultByte
);
  logic [BYTE_W-1:0] operandBuf [ROWS];
  logic [BYTE_W-1:0] acc0, acc1;
  logic [BYTE_W-1:0] opLead, opNext, opThird, opFourth;
  logic [ROW_W-1:0]  idxNext, idxThird, idxFourth;

  // wrap-around row indices relative to the row being built
  always_comb begin
    idxNext   = strobes.rowSel + ROW_W'(1);
    idxThird  = strobes.rowSel + ROW_W'(2);
    idxFourth = strobes.rowSel + ROW_W'(3);
    opLead    = operandBuf[strobes.rowSel];
    opNext    = operandBuf[idxNext];
    opThird   = operandBuf[idxThird];
    opFourth  = operandBuf[idxFourth];
  end

  generate
    for (genvar g = 0; g < ROWS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst)
          operandBuf[g] <= '0;
        else if (strobes.push && strobes.wrSel == ROW_W'(g))
          operandBuf[g] <= inByte;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc0 <= '0;
      acc1 <= '0;
    end else begin
      case (strobes.op)
        OP_DBL_LEAD:   acc0 <= dbl(opLead);
        OP_DBL_NEXT:   acc1 <= dbl(opNext);
        OP_FOLD_NEXT:  acc1 <= acc1 ^ opNext;
        OP_JOIN:       acc0 <= acc0 ^ acc1;
        OP_ADD_THIRD:  acc0 <= acc0 ^ opThird;
        OP_ADD_FOURTH: acc0 <= acc0 ^ opFourth;
        default: ;
      endcase
    end
  end

  assign resultByte = acc0;
endmodule

// File: rtl/colmix_ctrl.sv
module colmix_ctrl
  import colmix_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output logic          inReady,
  output ctrlStrobes_t  strobes
);
  typedef enum logic [2:0] {
    ST_LOAD, ST_DBL_A, ST_DBL_B, ST_FOLD, ST_JOIN, ST_ADD_C, ST_ADD_D, ST_EMIT
  } state_e;

  state_e           state, stateNext;
  logic [ROW_W-1:0] fillCnt, fillNext;
  logic [ROW_W-1:0] rowIdx, rowNext;
  logic             accept;
  logic             lastFill;
  logic             lastRow;

  assign inReady  = (state == ST_LOAD);
  assign accept   = inReady && inValid;
  assign lastFill = (fillCnt == ROW_W'(ROWS - 1));
  assign lastRow  = (rowIdx == ROW_W'(ROWS - 1));

  always_comb begin
    stateNext = state;
    fillNext  = fillCnt;
    rowNext   = rowIdx;
    strobes   = '{op: OP_NONE, rowSel: rowIdx, push: 1'b0, wrSel: fillCnt, emit: 1'b0};
    case (state)
      ST_LOAD: begin
        if (accept) begin
          strobes.push = 1'b1;
          if (lastFill) begin
            fillNext  = '0;
            rowNext   = '0;
            stateNext = ST_DBL_A;
          end else begin
            fillNext = fillCnt + ROW_W'(1);
          end
        end
      end
      ST_DBL_A: begin strobes.op = OP_DBL_LEAD;   stateNext = ST_DBL_B; end
      ST_DBL_B: begin strobes.op = OP_DBL_NEXT;   stateNext = ST_FOLD;  end
      ST_FOLD:  begin strobes.op = OP_FOLD_NEXT;  stateNext = ST_JOIN;  end
      ST_JOIN:  begin strobes.op = OP_JOIN;       stateNext = ST_ADD_C; end
      ST_ADD_C: begin strobes.op = OP_ADD_THIRD;  stateNext = ST_ADD_D; end
      ST_ADD_D: begin strobes.op = OP_ADD_FOURTH; stateNext = ST_EMIT;  end
      ST_EMIT: begin
        strobes.emit = 1'b1;
        if (lastRow) begin
          stateNext = ST_LOAD;
        end else begin
          rowNext   = rowIdx + ROW_W'(1);
          stateNext = ST_DBL_A;
        end
      end
      default: stateNext = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LOAD;
      fillCnt <= '0;
      rowIdx  <= '0;
    end else begin
      state   <= stateNext;
      fillCnt <= fillNext;
      rowIdx  <= rowNext;
    end
  end
endmodule

// File: rtl/colmix_serial.sv
module colmix_serial
  import colmix_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [BYTE_W-1:0]  inByte,
  input  logic               inValid,
  output logic               inReady,
  output logic [BYTE_W-1:0]  outByte,
  output logic [ROW_W-1:0]   outRow,
  output logic               outValid
);
  ctrlStrobes_t strobes;

  colmix_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .strobes (strobes)
  );

  colmix_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .inByte     (inByte),
    .resultByte (outByte)
  );

  assign outValid = strobes.emit;
  assign outRow   = strobes.rowSel;
endmodule

// File: rtl/colmix_chk.sv
module colmix_chk
  import colmix_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic [ROW_W-1:0] outRow,
  input logic             outValid
);
  logic [ROW_W-1:0] emitCnt;
  logic [ROW_W:0]   acceptCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      emitCnt   <= '0;
      acceptCnt <= '0;
    end else begin
      if (outValid) emitCnt <= emitCnt + ROW_W'(1);
      if (outValid && outRow == ROW_W'(ROWS - 1))
        acceptCnt <= '0;
      else if (inValid && inReady)
        acceptCnt <= acceptCnt + 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (inReady && !outValid));

  // R3
  closed_while_emitting_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  // R2
  no_fifth_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |-> (acceptCnt < (ROW_W+1)'(ROWS)));

  // R8
  full_column_before_emit_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (acceptCnt == (ROW_W+1)'(ROWS)));

  // R6
  row_order_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outRow == emitCnt));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R7
  reopen_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outRow == ROW_W'(ROWS - 1)) |=> inReady);
endmodule

bind colmix_serial colmix_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outRow   (outRow),
  .outValid (outValid)
);

// File: tb/tb_colmix_serial.sv
module tb_colmix_serial;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] inByte = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] outByte;
  logic [1:0] outRow;
  logic       outValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  colmix_serial dut (
    .clk(clk), .rst(rst), .inByte(inByte), .inValid(inValid),
    .inReady(inReady), .outByte(outByte), .outRow(outRow), .outValid(outValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // shift-and-add field multiply, independent of the unit's doubling chain
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] acc = '0;
    logic [15:0] prod = '0;
    for (int k = 0; k < 8; k++) if (b[k]) prod = prod ^ (16'(a) << k);
    for (int k = 15; k >= 8; k--) if (prod[k]) prod = prod ^ (16'h011B << (k - 8));
    acc = prod[8:0];
    return acc[7:0];
  endfunction

  function automatic logic [7:0] model(input logic [7:0] col [4], input int i);
    return gmul(8'h02, col[i]) ^ gmul(8'h03, col[(i+1)%4]) ^ col[(i+2)%4] ^ col[(i+3)%4];
  endfunction

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    inByte = b;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic pulseReset();
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Loads a column, then checks timing, order, values and input closure.
  task automatic runColumn(input logic [7:0] col [4], input logic [7:0] want [4],
                           input string tag, input bit press);
    int waitCyc;
    for (int k = 0; k < 4; k++) pushByte(col[k]);
    @(negedge clk);
    inValid = press;
    inByte = 8'hFF;
    waitCyc = 1;
    for (int r = 0; r < 4; r++) begin
      while (!outValid && waitCyc < 40) begin
        if (press) check(!inReady, "R3 input closed during compute", inReady, 0);
        @(negedge clk);
        waitCyc++;
      end
      check(waitCyc == 7, "R6 result spacing", waitCyc, 7);
      check(outRow == 2'(r), "R6 row order", outRow, r);
      check(outByte == want[r], {"R4 ", tag}, outByte, want[r]);
      check(!inReady, "R3 closed at emit", inReady, 0);
      @(negedge clk);
      waitCyc = 1;
    end
    check(inReady, "R7 reopen after row 3", inReady, 1);
    check(!outValid, "R6 pulse is one cycle", outValid, 0);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    check(inReady, "R1 ready after reset", inReady, 1);
    check(!outValid, "R1 no output after reset", outValid, 0);
  endtask

  task automatic testStandard();
    logic [7:0] c [4] = '{8'hDB, 8'h13, 8'h53, 8'h45};
    logic [7:0] w [4] = '{8'h8E, 8'h4D, 8'hA1, 8'hBC};
    runColumn(c, w, "standard column", 1'b0);
  endtask

  task automatic testReduction();
    logic [7:0] c [4] = '{8'h80, 8'h00, 8'h00, 8'h00};
    logic [7:0] w [4] = '{8'h1B, 8'h80, 8'h80, 8'h9B};
    runColumn(c, w, "R5 reduction column", 1'b0);
  endtask

  task automatic testPressure();
    logic [7:0] c [4] = '{8'hF2, 8'h0A, 8'h22, 8'h5C};
    logic [7:0] d [4] = '{8'h01, 8'h01, 8'h01, 8'h01};
    logic [7:0] w [4];
    for (int i = 0; i < 4; i++) w[i] = model(c, i);
    runColumn(c, w, "R3 column under input pressure", 1'b1);
    runColumn(d, d, "R2 column after pressure", 1'b0);
  endtask

  task automatic testResetLoad();
    logic [7:0] c [4] = '{8'h45, 8'h53, 8'h13, 8'hDB};
    logic [7:0] w [4];
    for (int i = 0; i < 4; i++) w[i] = model(c, i);
    pushByte(8'h77);
    pushByte(8'h99);
    pulseReset();
    testReset();
    runColumn(c, w, "R8 after reset in load", 1'b0);
  endtask

  task automatic testResetCompute();
    logic [7:0] c [4] = '{8'hC6, 8'hC6, 8'hC6, 8'hC6};
    bit seen = 0;
    for (int k = 0; k < 4; k++) pushByte(8'h3C + 8'(k));
    @(negedge clk);
    inValid = 1'b0;
    repeat (10) @(negedge clk);
    pulseReset();
    for (int k = 0; k < 20; k++) begin
      if (outValid) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R8 no output after mid-compute reset", seen, 0);
    runColumn(c, c, "R8 column after mid-compute reset", 1'b0);
  endtask

  task automatic testRandom();
    logic [7:0] c [4];
    logic [7:0] w [4];
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < 4; i++) c[i] = 8'($urandom);
      for (int i = 0; i < 4; i++) w[i] = model(c, i);
      runColumn(c, w, "random column", n[0]);
    end
  endtask

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testStandard();
    testReduction();
    testPressure();
    testResetLoad();
    testResetCompute();
    testRandom();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule